// File: doc/BRIEF.md
# Addressed Serial Receiver with Stop-Bit Checking

This block receives asynchronous serial frames from a single data line. Each frame has a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. The bit timing comes from an enable input that pulses sixteen times per bit period. The receiver samples each bit three times around its middle and takes the majority value. A start that has gone high again by mid-bit is dropped.

Software reaches the block through a small register port. There are five byte-wide locations:

| Address | Register |
|---|---|
| 0 | Control/status |
| 1 | Received byte (read only) |
| 2 | Node address |
| 3 | Address mask |
| 4 | Aux select (bit 0) |

The top bit of the control/status register is shared by two things: the upper mode bit and a sticky framing-error flag. The aux select bit decides which of the two that bit reaches, for both reads and writes.

In the nine-bit modes the receiver can filter frames by address. A frame whose ninth bit is 1 is an address frame. It is accepted only if it matches the node's own address or the broadcast address. Data frames, whose ninth bit is 0, are accepted only while the node is selected.

Top module: `addr_filter_uart_rx`

## Requirements
- R1: After reset, all five register locations (0..4) read as 0x00.
- R2: Control bit 4 enables the receiver. Control bits {7,6} (the mode bit reached at bit 7 with select = 0, then bit 6) set the mode:
  - 00: eight data bits, stop bit not checked.
  - 01: eight data bits, stop bit checked.
  - 10 and 11: nine data bits, stop bit checked.

  When a frame is accepted, its data byte (LSB first on the line) is loaded at location 1 and control bit 0 (receive-done) is set.
- R3: In the nine-bit modes, the ninth received bit of an accepted frame appears at control bit 2. In the eight-bit modes, bit 2 is loaded with 0.
- R4: In modes 01, 10 and 11, a stop bit sampled as 0 sets the framing-error flag. In mode 00, the stop bit never sets the flag.
- R5: The framing-error flag stays set through later frames, including frames with a good stop bit. It clears only when software writes 0 to control bit 7 while select = 1.
- R6: With select = 0, reads and writes of control bit 7 reach the upper mode bit. With select = 1, they reach the framing-error flag, and the mode bit is left unchanged.
- R7: Control bit 5 enables address filtering, which acts only in the nine-bit modes. An address frame is accepted when the received byte equals the node address (location 2) in every bit where the mask (location 3) is 1.
- R8: An address frame is also accepted when every bit that is 1 in (address OR mask) is 1 in the received byte. This is the broadcast address.
- R9: Each address frame selects the node when it matches and deselects it when it does not. While filtering is on, a data frame (ninth bit 0) is accepted only while the node is selected.
- R10: A frame rejected by the filter leaves the received byte, control bit 2 and receive-done unchanged.
- R11: A low pulse on the line that has ended before the middle of the start bit starts no frame.
- R12: With the receiver disabled, frames on the line have no effect.
- R13: Writing 0 to control bit 0 clears receive-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial data line, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
Faults in the bit counter or in the sample points show up in the very next accepted frame, as a shifted or corrupted byte at location 1. A wrong node-selected state shows up on the following data frame: it is either accepted or dropped where it should not be, and that is visible at receive-done and location 1. A framing flag that is cleared or set wrongly is visible as soon as software switches select to 1 and reads bit 7. The bench therefore reads every register after every frame.

// File: rtl/addr_filter_uart_rx.sv
module addr_filter_uart_rx #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] S_A   = CW'(OS/2 - 1);
  localparam logic [CW-1:0] S_B   = CW'(OS/2);
  localparam logic [CW-1:0] S_C   = CW'(OS/2 + 1);
  localparam logic [CW-1:0] S_END = CW'(OS - 1);

  logic [1:0] rx_sync;
  logic rxs;
  logic mode_hi, mode_lo, addr_en, rx_en, rx_done, ferr, sel, selected, rx9_q;
  logic [7:0] buf_q, own_addr, own_mask;
  logic running, b9;
  logic [CW-1:0] cnt;
  logic [3:0] bitpos;
  logic [1:0] smp;
  logic [7:0] sh;

  assign rxs = rx_sync[1];

  wire [1:0] mode     = {mode_hi, mode_lo};
  wire       nine     = mode_hi;
  wire       stop_chk = (mode != 2'b00);
  wire [3:0] last_pos = nine ? 4'd10 : 4'd9;
  wire       wr_ctrl  = reg_we && (reg_addr == 3'd0);
  wire       vote     = (smp[0] & smp[1]) | (smp[0] & rxs) | (smp[1] & rxs);
  wire       at_vote  = os_tick && running && (cnt == S_C);
  wire       frame_end = at_vote && (bitpos == last_pos);
  wire       stop_bad = stop_chk && !vote;

  wire [7:0] bcast     = own_addr | own_mask;
  wire       given_hit = ((sh ^ own_addr) & own_mask) == 8'h00;
  wire       bcast_hit = (sh & bcast) == bcast;
  wire       hit       = given_hit | bcast_hit;
  wire       filter_on = addr_en && nine;
  wire       accept    = !filter_on || (b9 ? hit : selected);
  wire       load      = frame_end && accept;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      bitpos  <= 4'd0;
      smp     <= 2'b00;
      sh      <= 8'h00;
      b9      <= 1'b0;
    end else if (os_tick) begin
      if (!running) begin
        if (rx_en && !rxs) begin
          running <= 1'b1;
          cnt     <= '0;
          bitpos  <= 4'd0;
        end
      end else begin
        cnt <= (cnt == S_END) ? '0 : cnt + CW'(1);
        if (cnt == S_A) smp[0] <= rxs;
        if (cnt == S_B) smp[1] <= rxs;
        if (cnt == S_C) begin
          if (bitpos == 4'd0) begin
            if (vote) running <= 1'b0;
          end else if (bitpos == last_pos) begin
            running <= 1'b0;
          end else if (bitpos <= 4'd8) begin
            sh <= {vote, sh[7:1]};
          end else begin
            b9 <= vote;
          end
        end
        if (cnt == S_END) bitpos <= bitpos + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_hi  <= 1'b0;
      mode_lo  <= 1'b0;
      addr_en  <= 1'b0;
      rx_en    <= 1'b0;
      rx_done  <= 1'b0;
      ferr     <= 1'b0;
      sel      <= 1'b0;
      selected <= 1'b0;
      rx9_q    <= 1'b0;
      buf_q    <= 8'h00;
      own_addr <= 8'h00;
      own_mask <= 8'h00;
    end else begin
      if (wr_ctrl) begin
        if (sel) ferr    <= reg_wdata[7];
        else     mode_hi <= reg_wdata[7];
        mode_lo <= reg_wdata[6];
        addr_en <= reg_wdata[5];
        rx_en   <= reg_wdata[4];
        rx_done <= reg_wdata[0];
      end
      if (reg_we && reg_addr == 3'd2) own_addr <= reg_wdata;
      if (reg_we && reg_addr == 3'd3) own_mask <= reg_wdata;
      if (reg_we && reg_addr == 3'd4) sel      <= reg_wdata[0];
      if (frame_end && stop_bad) ferr <= 1'b1;
      if (frame_end && filter_on && b9) selected <= hit;
      if (load) begin
        rx_done <= 1'b1;
        buf_q   <= sh;
        rx9_q   <= nine & b9;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {sel ? ferr : mode_hi, mode_lo, addr_en, rx_en, 1'b0, rx9_q, 1'b0, rx_done};
      3'd1:    reg_rdata = buf_q;
      3'd2:    reg_rdata = own_addr;
      3'd3:    reg_rdata = own_mask;
      3'd4:    reg_rdata = {7'd0, sel};
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_done_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> ($past(frame_end) || $past(wr_ctrl && reg_wdata[0])));

  assert_no_stop_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && mode == 2'b00 && !(wr_ctrl && sel)) |=> $stable(ferr));

  assert_ferr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !(wr_ctrl && sel)) |=> ferr);

  assert_mode_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && sel) |=> $stable(mode_hi));

  assert_reject_keeps_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && filter_on && b9 && !hit) |=> ($stable(buf_q) && $stable(rx9_q)));

  assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !rx_en) |=> !running);
endmodule

// File: tb/addr_filter_uart_rx_test.sv
module addr_filter_uart_rx_test;
  localparam int CLK_P = 10;
  localparam int BIT_CLKS = 64;

  logic clk = 0, rst_n = 0, os_tick = 0, rxd = 1, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;

  addr_filter_uart_rx uut (.clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    os_tick = 1;
    @(negedge clk);
    os_tick = 0;
  end

  int n_chk = 0, n_fail = 0, sent = 0, checked = 0;
  bit finished = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  logic [1:0] cfg_mode = 0;
  logic cfg_aen = 0, cfg_rxen = 0;
  logic [7:0] own_a = 0, own_m = 0;
  logic m_sel = 0, m_ferr = 0, m_rx9 = 0;
  logic [7:0] m_buf = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9v, input logic stopv, input string tag);
    logic nine, filt, acc, gh, bh;
    nine = cfg_mode[1];
    filt = cfg_aen && nine;
    gh = (((d ^ own_a) & own_m) == 8'h00);
    bh = ((d & (own_a | own_m)) == (own_a | own_m));
    acc = cfg_rxen && (!filt || (b9v ? (gh || bh) : m_sel));
    if (cfg_rxen && filt && b9v) m_sel = gh || bh;
    if (cfg_rxen && cfg_mode != 2'b00 && !stopv) m_ferr = 1;
    if (acc) begin m_buf = d; m_rx9 = nine & b9v; end
    exp_q.push_back({m_buf, m_rx9, acc, m_ferr});
    tag_q.push_back(tag);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (nine) drive_bit(b9v);
    drive_bit(stopv);
    rxd = 1;
    repeat (3*BIT_CLKS) @(negedge clk);
    sent++;
    wait (checked == sent);
  endtask

  task automatic glitch(input string tag);
    exp_q.push_back({m_buf, m_rx9, 1'b0, m_ferr});
    tag_q.push_back(tag);
    @(negedge clk);
    rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (3*BIT_CLKS) @(negedge clk);
    sent++;
    wait (checked == sent);
  endtask

  initial forever begin
    logic [10:0] e;
    string t;
    logic [7:0] c0, c1, c2, b;
    wait (checked < sent);
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    rd(3'd0, c0);
    rd(3'd1, b);
    chk({7'd0, c0[0]}, {7'd0, e[1]}, {t, " receive-done"});
    chk(b, e[10:3], {t, " received byte"});
    chk({7'd0, c0[2]}, {7'd0, e[2]}, {t, " ninth bit"});
    wr(3'd4, 8'h01);
    rd(3'd0, c1);
    chk({7'd0, c1[7]}, {7'd0, e[0]}, {t, " framing flag"});
    wr(3'd0, {c1[7], c1[6:1], 1'b0});
    rd(3'd0, c2);
    chk({7'd0, c2[0]}, 8'h00, "R13 receive-done cleared by write");
    wr(3'd4, 8'h00);
    checked++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      chk(r, 8'h00, "R1 reset value");
    end

    wr(3'd0, 8'h50); cfg_mode = 2'b01; cfg_rxen = 1;
    send(8'hA5, 0, 1, "R2 mode 01 frame");
    send(8'h3C, 0, 1, "R2 second frame");
    send(8'h81, 0, 0, "R4 bad stop sets flag");
    send(8'h42, 0, 1, "R5 good stop keeps flag");

    wr(3'd4, 8'h01);
    wr(3'd0, 8'h50); m_ferr = 0;
    rd(3'd0, r); chk({7'd0, r[7]}, 8'h00, "R5 flag cleared by write 0");
    wr(3'd4, 8'h00);
    rd(3'd0, r); chk({7'd0, r[7]}, 8'h00, "R6 mode bit untouched by flag write");
    wr(3'd0, 8'hD0); cfg_mode = 2'b11;
    rd(3'd0, r); chk({7'd0, r[7]}, 8'h01, "R6 mode bit written with select 0");
    wr(3'd4, 8'h01);
    rd(3'd0, r); chk({7'd0, r[7]}, 8'h00, "R6 flag unaffected by mode write");
    wr(3'd4, 8'h00);

    send(8'h5A, 1, 1, "R3 ninth bit one");
    send(8'h11, 0, 1, "R3 ninth bit zero");

    wr(3'd0, 8'h10); cfg_mode = 2'b00;
    send(8'hC3, 0, 0, "R4 mode 00 ignores stop");

    wr(3'd2, 8'h5C); own_a = 8'h5C;
    wr(3'd3, 8'hF0); own_m = 8'hF0;
    wr(3'd0, 8'hB0); cfg_mode = 2'b10; cfg_aen = 1;
    send(8'h33, 1, 1, "R10 unmatched address rejected");
    send(8'h22, 0, 1, "R9 data while unselected");
    send(8'h57, 1, 1, "R7 given address match");
    send(8'h99, 0, 1, "R9 data while selected");
    send(8'hFD, 1, 1, "R8 broadcast match");
    send(8'h12, 1, 1, "R10 deselecting address");
    send(8'h44, 0, 1, "R9 data after deselect");

    glitch("R11 short start pulse");

    wr(3'd0, 8'h40); cfg_mode = 2'b01; cfg_aen = 0; cfg_rxen = 0;
    send(8'h77, 0, 1, "R12 receiver disabled");

    finish_run();
  end
endmodule